// File: doc/BRIEF.md
# Synchronous Serial Slave Shifter

This block is an 8-bit shift register that acts as the slave on a three-wire synchronous serial link. The external master drives the shift clock, and the block never generates one. The host loads a byte, then sets the busy flag to arm the shifter. The master then toggles the shift clock. On each rising edge of the gated shift clock, one bit enters from the serial input at the least significant end. The most significant bit leaves on the serial output, and that output changes only on falling edges. The busy flag clears by itself after eight rising edges, and a one-cycle completion pulse is raised in the same cycle.

Both serial inputs pass through two-flop synchronizers, and all edges are found in the system clock domain. For this reason, each shift clock level must last at least two system clock cycles. The internal shift clock is the synchronized shift clock ANDed with an active state. The active state is set by arming and cleared by loading. As a result, arming while the shift clock is high produces a rising edge, which shifts in one bit and counts as one of the eight. Shifting also goes on after busy clears, for as long as the master keeps clocking. A load taken while the synchronized shift clock is high is still performed, but it is reported with a one-cycle load-error pulse.

Top module: `sync_slave_shifter`

## Requirements
- R1: After reset, data_o, so_o, busy_o, done_irq_o and load_err_o are all 0, and the shifter is in standby (inactive).
- R2: A load_i pulse makes data_o equal load_data_i one clock later. It also makes so_o equal bit 7 of that value, and it puts the shifter into standby.
- R3: An arm_i pulse sets busy_o one clock later, clears the edge count and makes the shifter active.
- R4: While active, each rising edge of the synchronized shift clock shifts data_o left by one. The synchronized serial input enters bit 0. The new value appears three clock edges after sk_i rises.
- R5: busy_o clears after the eighth counted rising edge since arming. done_irq_o is high for exactly one cycle, in the same cycle that busy_o first reads 0.
- R6: so_o takes the new bit 7 of data_o only on a falling edge of the gated shift clock. It holds its value across rising edges.
- R7: After busy_o has cleared, an active shifter keeps shifting on every rising edge without raising done_irq_o again.
- R8: Arming while the synchronized shift clock is high creates one immediate rising edge. That edge shifts in the current serial input bit and counts toward the eight, so seven more master pulses clear busy_o.
- R9: A load while the synchronized shift clock is high raises load_err_o for one cycle. The load is still performed.
- R10: In standby, shift clock edges leave data_o and so_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Host pulse: load the shift register |
| load_data_i | input | 8 | Value to load |
| arm_i | input | 1 | Host pulse: set busy and activate the shifter |
| data_o | output | 8 | Current shift register contents |
| busy_o | output | 1 | Busy flag, cleared after eight counted edges |
| done_irq_o | output | 1 | One-cycle pulse when busy clears |
| load_err_o | output | 1 | One-cycle pulse: load taken while the shift clock was high |
| sk_i | input | 1 | Shift clock from the master |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out, most significant bit first |

## Verification
Host-side results are registered, so the effects of a load or an arm are sampled one clock after the pulse. A spurious edge caused by arming takes one clock more, because the active flag must first reach the edge detector. Pin-side results take three clock edges: two synchronizer stages and the output register. The bench therefore holds each shift clock level for four clocks and samples at the falling clock edge after that wait. This places every comparison after the result is due and before the next pin change. The completion pulses are counted at every falling clock edge and compared with the count predicted by the bench model.

// File: rtl/sss_pkg.sv
package sss_pkg;
  // Edge events of the gated shift clock, seen in the system clock domain.
  typedef struct packed {
    logic rise;
    logic fall;
  } sss_edge_t;
endpackage

// File: rtl/sss_sync.sv
module sss_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sss_edge.sv
module sss_edge
  import sss_pkg::*;
(
  input  logic      clk,
  input  logic      rst_sn,
  input  logic      sk_s,
  input  logic      active,
  output sss_edge_t ev
);
  logic gclk;
  logic gclk_q;

  // Gated shift clock: a low-to-high step of 'active' while sk_s is high
  // counts as a real rising edge.
  assign gclk = sk_s & active;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) gclk_q <= 1'b0;
    else         gclk_q <= gclk;
  end

  always_comb begin
    ev.rise = gclk & ~gclk_q;
    ev.fall = ~gclk & gclk_q;
  end
endmodule

// File: rtl/sss_ctrl.sv
module sss_ctrl #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic arm_i,
  input  logic load_i,
  input  logic sk_s,
  input  logic rise,
  output logic active_o,
  output logic busy_o,
  output logic done_o,
  output logic load_err_o
);
  localparam int          CW   = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          active_q, active_n;
  logic          busy_q,   busy_n;
  logic [CW-1:0] cnt_q,    cnt_n;
  logic          done_q,   done_n;
  logic          err_q,    err_n;

  always_comb begin
    active_n = active_q;
    busy_n   = busy_q;
    cnt_n    = cnt_q;
    done_n   = 1'b0;
    err_n    = load_i & sk_s;

    if (arm_i)       active_n = 1'b1;
    else if (load_i) active_n = 1'b0;

    if (arm_i) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end else if (rise && busy_q) begin
      if (cnt_q == LAST) begin
        busy_n = 1'b0;
        cnt_n  = '0;
        done_n = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      active_q <= 1'b0;
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      active_q <= active_n;
      busy_q   <= busy_n;
      cnt_q    <= cnt_n;
      done_q   <= done_n;
      err_q    <= err_n;
    end
  end

  assign active_o   = active_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign load_err_o = err_q;
endmodule

// File: rtl/sss_shreg.sv
module sss_shreg
  import sss_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         si_s,
  input  sss_edge_t    ev,
  output logic [W-1:0] data_o,
  output logic         so_o
);
  logic [W-1:0] sr_q, sr_n;
  logic         so_q, so_n;

  always_comb begin
    sr_n = sr_q;
    so_n = so_q;
    if (load_i) begin
      sr_n = load_data_i;
      so_n = load_data_i[W-1];
    end else begin
      if (ev.rise) sr_n = {sr_q[W-2:0], si_s};
      // Output moves on the falling edge so it is settled for the next rise.
      if (ev.fall) so_n = sr_q[W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sr_q <= '0;
      so_q <= 1'b0;
    end else begin
      sr_q <= sr_n;
      so_q <= so_n;
    end
  end

  assign data_o = sr_q;
  assign so_o   = so_q;
endmodule

// File: rtl/sync_slave_shifter.sv
module sync_slave_shifter
  import sss_pkg::*;
#(
  parameter int W         = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         arm_i,
  output logic [W-1:0] data_o,
  output logic         busy_o,
  output logic         done_irq_o,
  output logic         load_err_o,
  input  logic         sk_i,
  input  logic         si_i,
  output logic         so_o
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic      sk_s;
  logic      si_s;
  logic      active;
  sss_edge_t ev;

  sss_sync #(.W(2), .STAGES(SYNC_STGS)) u_sync (
    .clk    (clk),
    .rst_sn (rst_sn),
    .d_i    ({sk_i, si_i}),
    .q_o    ({sk_s, si_s})
  );

  sss_edge u_edge (
    .clk    (clk),
    .rst_sn (rst_sn),
    .sk_s   (sk_s),
    .active (active),
    .ev     (ev)
  );

  sss_ctrl #(.W(W)) u_ctrl (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .arm_i      (arm_i),
    .load_i     (load_i),
    .sk_s       (sk_s),
    .rise       (ev.rise),
    .active_o   (active),
    .busy_o     (busy_o),
    .done_o     (done_irq_o),
    .load_err_o (load_err_o)
  );

  sss_shreg #(.W(W)) u_shreg (
    .clk         (clk),
    .rst_sn      (rst_sn),
    .load_i      (load_i),
    .load_data_i (load_data_i),
    .si_s        (si_s),
    .ev          (ev),
    .data_o      (data_o),
    .so_o        (so_o)
  );
endmodule

// File: rtl/sss_checker.sv
module sss_checker
  import sss_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_sn,
  input logic         load_i,
  input logic [W-1:0] load_data_i,
  input logic         arm_i,
  input logic [W-1:0] data_o,
  input logic         busy_o,
  input logic         done_irq_o,
  input logic         load_err_o,
  input logic         so_o,
  input logic         sk_s,
  input logic         si_s,
  input logic         active,
  input sss_edge_t    ev
);
  p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    load_i |=> data_o == $past(load_data_i));

  p_arm_busy_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    arm_i |=> busy_o);

  p_shift_in_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (ev.rise && !load_i) |=> data_o == {$past(data_o[W-2:0]), $past(si_s)});

  p_done_on_clear_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(busy_o) |-> done_irq_o);

  p_done_not_busy_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    done_irq_o |-> !busy_o);

  p_so_hold_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (ev.rise && !load_i) |=> $stable(so_o));

  p_arm_high_edge_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    ($rose(active) && sk_s) |-> ev.rise);

  p_load_err_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (load_i && sk_s) |=> load_err_o);

  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    load_err_o |-> $past(load_i));

  p_standby_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (!active && !load_i) |=> $stable(data_o));
endmodule

bind sync_slave_shifter sss_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst_sn      (rst_sn),
  .load_i      (load_i),
  .load_data_i (load_data_i),
  .arm_i       (arm_i),
  .data_o      (data_o),
  .busy_o      (busy_o),
  .done_irq_o  (done_irq_o),
  .load_err_o  (load_err_o),
  .so_o        (so_o),
  .sk_s        (sk_s),
  .si_s        (si_s),
  .active      (active),
  .ev          (ev)
);

// File: tb/sim_sync_slave_shifter.sv
`timescale 1ns/1ps
module sim_sync_slave_shifter;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         load_i, arm_i, sk_i, si_i;
  logic [W-1:0] load_data_i;
  logic [W-1:0] data_o;
  logic         busy_o, done_irq_o, load_err_o, so_o;

  always #2.5 clk = ~clk;

  sync_slave_shifter #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_data_i(load_data_i),
    .arm_i(arm_i), .data_o(data_o), .busy_o(busy_o), .done_irq_o(done_irq_o),
    .load_err_o(load_err_o), .sk_i(sk_i), .si_i(si_i), .so_o(so_o)
  );

  int checks = 0, fails = 0, done_seen = 0, done_exp = 0;
  bit finished = 0;

  // Bench model state
  logic [W-1:0] m_sr;
  logic m_so, m_busy, m_active, m_sk, m_si;
  int   m_cnt;

  always @(negedge clk) if (rst_n && done_irq_o) done_seen++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] shl(input logic [W-1:0] v, input logic b);
    return {v[W-2:0], b};
  endfunction

  task automatic do_load(input logic [W-1:0] v);
    @(negedge clk); load_i = 1'b1; load_data_i = v;
    @(negedge clk); load_i = 1'b0;
    m_sr = v; m_so = v[W-1]; m_active = 1'b0;
    chk("R2 data", data_o, m_sr);
    chk("R2 so", so_o, m_so);
    chk("R9 load_err", load_err_o, m_sk);
  endtask

  task automatic do_arm();
    bit spur;
    @(negedge clk); arm_i = 1'b1;
    @(negedge clk); arm_i = 1'b0;
    chk("R3 busy", busy_o, 1);
    spur = !m_active && m_sk;
    m_active = 1'b1; m_busy = 1'b1; m_cnt = 0;
    if (spur) begin
      m_sr = shl(m_sr, m_si);
      m_cnt = 1;
    end
    repeat (2) @(negedge clk);
    chk(spur ? "R8 data" : "R3 data", data_o, m_sr);
    chk("R3 busy held", busy_o, 1);
  endtask

  task automatic half_low(input logic b);
    @(negedge clk); sk_i = 1'b0; si_i = b; m_si = b;
    repeat (4) @(negedge clk);
    if (m_active && m_sk) m_so = m_sr[W-1];
    m_sk = 1'b0;
    chk("R6 so fall", so_o, m_so);
    chk(m_active ? "R4 data fall" : "R10 data fall", data_o, m_sr);
  endtask

  task automatic half_high();
    string tag;
    @(negedge clk); sk_i = 1'b1;
    repeat (4) @(negedge clk);
    tag = !m_active ? "R10 data" : (m_busy ? "R4 data" : "R7 data");
    if (m_active && !m_sk) begin
      m_sr = shl(m_sr, m_si);
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == W) begin m_busy = 1'b0; done_exp++; end
      end
    end
    m_sk = 1'b1;
    chk(tag, data_o, m_sr);
    chk("R5 busy", busy_o, m_busy);
    chk("R5 done count", done_seen, done_exp);
    chk(m_active ? "R6 so hold" : "R10 so", so_o, m_so);
  endtask

  task automatic pulse(input logic b);
    half_low(b);
    half_high();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    int unused_seed;
    logic [W-1:0] v;
    rst_n = 1'b0; load_i = 1'b0; arm_i = 1'b0; sk_i = 1'b0; si_i = 1'b0;
    load_data_i = '0;
    m_sr = '0; m_so = 1'b0; m_busy = 1'b0; m_active = 1'b0; m_sk = 1'b0;
    m_si = 1'b0; m_cnt = 0;
    unused_seed = $urandom(32'd20231);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 data", data_o, 0);
    chk("R1 so", so_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_irq_o, 0);
    chk("R1 load_err", load_err_o, 0);

    // R10: standby ignores the shift clock before any arm
    pulse(1'b1);
    do_load(8'hA5);
    pulse(1'b1); pulse(1'b0); pulse(1'b1);

    // R3, R4, R5, R6: a full byte, armed with SK low
    do_arm();
    for (int k = 0; k < W; k++) pulse(k[0] ^ k[2]);

    // R7: shifting continues after busy cleared
    pulse(1'b1); pulse(1'b0); pulse(1'b1);

    // R9: load with SK high (SK is high after the last pulse)
    do_load(8'h3C);

    // R8: arm with SK high -> spurious edge, seven more pulses finish
    si_i = 1'b1; m_si = 1'b1;
    do_arm();
    for (int k = 0; k < W - 1; k++) pulse(k[0]);
    pulse(1'b0);

    // Constrained random rounds
    for (int i = 0; i < 24; i++) begin
      if ($urandom % 3 == 0) half_high();
      else half_low(1'($urandom));
      v = W'($urandom);
      do_load(v);
      if ($urandom % 2 == 0) half_high();
      do_arm();
      for (int k = 0; k < W + int'($urandom % 3); k++) pulse(1'($urandom));
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule